// File: doc/BRIEF.md
# Interrupt Vector and DMA Request Unit

This block gathers the event flags of a serial bus controller into one sticky status register and turns them into a single interrupt line and two DMA request lines, one for receive and one for transmit. The transfer logic reports events through one-cycle set pulses, one wire per flag. Software uses a small 16-bit register port to set a 5-bit interrupt enable mask and the two DMA enables. It can read the status, and it reads a vector register that both reports and acknowledges the highest-priority pending enabled flag.

The vector register treats flag 0 as the highest priority. A read returns the 1-based position of the lowest pending enabled flag, and clears that one flag at the clock edge where the read is sampled. When a DMA channel is enabled, its ready flag is served by DMA and no longer raises an interrupt: writing a DMA enable also clears the matching interrupt enable bit. Register reads are combinational from the current state. Writes, set pulses and the acknowledge clear all take effect at the same rising edge.

The block has no state machine. All state is held in three registers: status, enable mask and DMA configuration.

Top module: `irq_vec_dreq`

## Requirements
- R1: A synchronous active-high reset clears status, enable mask and both DMA enables. After reset every register reads 0 (except the live busy bit 12 of status), and irq, rx_dreq and tx_dreq are low.
- R2: A write with acc_sel=0 (mask) stores acc_wdata[4:0]. A mask read returns the stored value in bits 4:0 and zeros above.
- R3: A set pulse on flag_set[b] makes status bit b read 1 from the next cycle on, and the bit stays set until it is acknowledged. Only positions 1,2,3,4,9,10,11,15 are flags (bit 3 receive ready, bit 4 transmit ready). Pulses at any other position are ignored.
- R4: A read with acc_sel=1 (status) returns the status flags with bit 12 replaced by the current value of bus_busy.
- R5: irq is high exactly when some bit b in 0..4 has status bit b and mask bit b both set.
- R6: A read with acc_sel=2 (vector) returns 1 plus the position of the lowest bit set in (status[4:0] AND mask), or 0 when there is none. With acc_rd high, that one status bit is cleared at the next edge and no other bit changes.
- R7: If a set pulse for a flag arrives in the same cycle as the vector read that acknowledges it, the set wins and the flag stays 1.
- R8: A write with acc_sel=3 (DMA) keeps only bit 15 (receive DMA enable) and bit 7 (transmit DMA enable). A DMA read returns those two bits and zeros elsewhere.
- R9: A DMA write with bit 15 set clears mask bit 3, and one with bit 7 set clears mask bit 4. All other mask bits are kept.
- R10: rx_dreq equals receive DMA enable AND status bit 3. tx_dreq equals transmit DMA enable AND status bit 4.
- R11: Writes with acc_sel=1 or acc_sel=2 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_sel | input | 2 | Register select: 0 mask, 1 status, 2 vector, 3 DMA |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe; used only for the vector acknowledge |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data of the selected register, combinational |
| flag_set | input | 16 | One-cycle set pulses, one per status position |
| bus_busy | input | 1 | Live bus-busy level, shown in status bit 12 |
| irq | output | 1 | Interrupt request |
| rx_dreq | output | 1 | Receive DMA request |
| tx_dreq | output | 1 | Transmit DMA request |

## Verification
The assertions check the following on every cycle: set pulses latch at flag positions, a mask write stores its low bits, DMA enables knock out the matching mask bits, status and vector writes leave state untouched, and the request lines stay low unless their DMA enable is on. Other behaviour can only be shown by the bench's scenarios. These are the order in which repeated vector reads drain several pending flags, the set-wins collision between an acknowledge and a fresh pulse, the live busy bit, and the agreement of read data with a reference model over long random mixes of pulses and accesses.

// File: rtl/ivdr_pkg.sv
package ivdr_pkg;
    localparam int DATA_W = 16;
    localparam int EN_W   = 5;

    typedef enum logic [1:0] {
        SEL_MASK   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_VECTOR = 2'd2,
        SEL_DMA    = 2'd3
    } reg_sel_e;

    localparam int FLG_RX_READY = 3;
    localparam int FLG_TX_READY = 4;
    localparam int BUSY_POS     = 12;
    localparam int RXDMA_POS    = 15;
    localparam int TXDMA_POS    = 7;

    // positions that hold a real sticky flag
    localparam logic [DATA_W-1:0] FLAG_DEF = 16'h8E1E;
endpackage

// File: rtl/ivdr_prio_enc.sv
module ivdr_prio_enc #(
    parameter int W     = 5,
    parameter int OUT_W = 16
) (
    input  logic [W-1:0]     pend,
    output logic [W-1:0]     first_oh,
    output logic [OUT_W-1:0] vec_idx
);
    // scan from top so the lowest set bit is the last to assign
    always_comb begin
        first_oh = '0;
        vec_idx  = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (pend[i]) begin
                first_oh    = '0;
                first_oh[i] = 1'b1;
                vec_idx     = OUT_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/ivdr_status_reg.sv
module ivdr_status_reg
    import ivdr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_pulse,
    input  logic [W-1:0] ack_clr,
    output logic [W-1:0] status_q
);
    localparam logic [W-1:0] DEF = W'(FLAG_DEF);

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else begin
            // set applied after the clear: a same-cycle pulse wins
            status_q <= (status_q & ~ack_clr) | (set_pulse & DEF);
        end
    end
endmodule

// File: rtl/ivdr_cfg_regs.sv
module ivdr_cfg_regs
    import ivdr_pkg::*;
#(
    parameter int MW = EN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mask_we,
    input  logic          dma_we,
    input  logic [MW-1:0] mask_wd,
    input  logic          rxdma_wd,
    input  logic          txdma_wd,
    output logic [MW-1:0] mask_q,
    output logic          rxdma_q,
    output logic          txdma_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            rxdma_q <= 1'b0;
            txdma_q <= 1'b0;
        end else if (mask_we) begin
            mask_q <= mask_wd;
        end else if (dma_we) begin
            rxdma_q <= rxdma_wd;
            txdma_q <= txdma_wd;
            if (rxdma_wd) mask_q[FLG_RX_READY] <= 1'b0;
            if (txdma_wd) mask_q[FLG_TX_READY] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_vec_dreq.sv
module irq_vec_dreq
    import ivdr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  acc_sel,
    input  logic        acc_wr,
    input  logic        acc_rd,
    input  logic [15:0] acc_wdata,
    output logic [15:0] acc_rdata,
    input  logic [15:0] flag_set,
    input  logic        bus_busy,
    output logic        irq,
    output logic        rx_dreq,
    output logic        tx_dreq
);
    reg_sel_e            sel;
    logic [DATA_W-1:0]   status_q;
    logic [EN_W-1:0]     mask_q;
    logic                rxdma_q;
    logic                txdma_q;
    logic [EN_W-1:0]     pending;
    logic [EN_W-1:0]     first_oh;
    logic [DATA_W-1:0]   vec_idx;
    logic [DATA_W-1:0]   ack_clr;
    logic                vec_ack;

    assign sel     = reg_sel_e'(acc_sel);
    assign pending = status_q[EN_W-1:0] & mask_q;
    assign vec_ack = acc_rd && (sel == SEL_VECTOR);
    assign ack_clr = vec_ack ? DATA_W'(first_oh) : '0;

    ivdr_prio_enc #(.W(EN_W), .OUT_W(DATA_W)) u_enc (
        .pend     (pending),
        .first_oh (first_oh),
        .vec_idx  (vec_idx)
    );

    ivdr_status_reg #(.W(DATA_W)) u_status (
        .clk       (clk),
        .rst       (rst),
        .set_pulse (flag_set),
        .ack_clr   (ack_clr),
        .status_q  (status_q)
    );

    ivdr_cfg_regs #(.MW(EN_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .mask_we  (acc_wr && (sel == SEL_MASK)),
        .dma_we   (acc_wr && (sel == SEL_DMA)),
        .mask_wd  (acc_wdata[EN_W-1:0]),
        .rxdma_wd (acc_wdata[RXDMA_POS]),
        .txdma_wd (acc_wdata[TXDMA_POS]),
        .mask_q   (mask_q),
        .rxdma_q  (rxdma_q),
        .txdma_q  (txdma_q)
    );

    always_comb begin
        acc_rdata = '0;
        unique case (sel)
            SEL_MASK:   acc_rdata = DATA_W'(mask_q);
            SEL_STATUS: begin
                acc_rdata           = status_q;
                acc_rdata[BUSY_POS] = bus_busy;
            end
            SEL_VECTOR: acc_rdata = vec_idx;
            SEL_DMA:    begin
                acc_rdata[RXDMA_POS] = rxdma_q;
                acc_rdata[TXDMA_POS] = txdma_q;
            end
        endcase
    end

    assign irq     = |pending;
    assign rx_dreq = rxdma_q & status_q[FLG_RX_READY];
    assign tx_dreq = txdma_q & status_q[FLG_TX_READY];
endmodule

// File: rtl/ivdr_checker.sv
module ivdr_checker
    import ivdr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [1:0]  acc_sel,
    input logic        acc_wr,
    input logic        acc_rd,
    input logic [15:0] acc_wdata,
    input logic [15:0] acc_rdata,
    input logic [15:0] flag_set,
    input logic [15:0] status_q,
    input logic [4:0]  mask_q,
    input logic        rxdma_q,
    input logic        txdma_q,
    input logic        irq,
    input logic        rx_dreq,
    input logic        tx_dreq
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!irq && !rx_dreq && !tx_dreq && mask_q == '0));

    a_r2_mask_store: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && acc_sel == 2'd0) |=> (mask_q == $past(acc_wdata[4:0])));

    a_r3_flag_latch: assert property (@(posedge clk) disable iff (rst)
        (flag_set != '0) |=>
            ((status_q & $past(flag_set & FLAG_DEF)) == $past(flag_set & FLAG_DEF)));

    a_r5_irq_needs_mask: assert property (@(posedge clk) disable iff (rst)
        irq |-> (mask_q != '0));

    a_r6_vec_range: assert property (@(posedge clk) disable iff (rst)
        (acc_sel == 2'd2) |-> (acc_rdata <= 16'd5));

    a_r9_dma_drops_mask: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && acc_sel == 2'd3 && (acc_wdata[15] || acc_wdata[7])) |=>
            ((!$past(acc_wdata[15]) || !mask_q[3]) && (!$past(acc_wdata[7]) || !mask_q[4])));

    a_r10_dreq_gate: assert property (@(posedge clk) disable iff (rst)
        (rx_dreq |-> rxdma_q) and (tx_dreq |-> txdma_q));

    a_r11_status_write_inert: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && !acc_rd && (acc_sel == 2'd1 || acc_sel == 2'd2) && flag_set == '0)
            |=> (status_q == $past(status_q) && mask_q == $past(mask_q)));
endmodule

bind irq_vec_dreq ivdr_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_sel   (acc_sel),
    .acc_wr    (acc_wr),
    .acc_rd    (acc_rd),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .flag_set  (flag_set),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .rxdma_q   (rxdma_q),
    .txdma_q   (txdma_q),
    .irq       (irq),
    .rx_dreq   (rx_dreq),
    .tx_dreq   (tx_dreq)
);

// File: tb/tb_irq_vec_dreq.sv
module tb_irq_vec_dreq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  acc_sel = '0;
    logic        acc_wr = 1'b0;
    logic        acc_rd = 1'b0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;
    logic [15:0] flag_set = '0;
    logic        bus_busy = 1'b0;
    logic        irq, rx_dreq, tx_dreq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference state
    logic [15:0] m_st  = '0;
    logic [4:0]  m_msk = '0;
    logic        m_rx  = 1'b0;
    logic        m_tx  = 1'b0;

    localparam logic [15:0] DEF = 16'h8E1E;

    always #2.5 clk = ~clk;

    irq_vec_dreq dut (
        .clk(clk), .rst(rst), .acc_sel(acc_sel), .acc_wr(acc_wr), .acc_rd(acc_rd),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .flag_set(flag_set),
        .bus_busy(bus_busy), .irq(irq), .rx_dreq(rx_dreq), .tx_dreq(tx_dreq)
    );

    function automatic logic [15:0] f_vec();
        for (int i = 4; i >= 0; i--) ; // placeholder-free: scan below
        for (int i = 0; i < 5; i++)
            if (m_st[i] && m_msk[i]) return 16'(i + 1);
        return 16'd0;
    endfunction

    function automatic logic [15:0] f_read(input logic [1:0] s);
        logic [15:0] r;
        case (s)
            2'd0: r = {11'd0, m_msk};
            2'd1: begin r = m_st; r[12] = bus_busy; end
            2'd2: r = f_vec();
            default: begin r = '0; r[15] = m_rx; r[7] = m_tx; end
        endcase
        return r;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input bit wr, input bit rd, input logic [1:0] s,
                        input logic [15:0] wd, input logic [15:0] set, input string tag);
        logic [15:0] v;
        @(negedge clk);
        acc_wr = wr; acc_rd = rd; acc_sel = s; acc_wdata = wd; flag_set = set;
        #1;
        if (rd) check(tag, acc_rdata, f_read(s));
        check("R5 irq", {15'd0, irq}, {15'd0, |(m_st[4:0] & m_msk)});
        check("R10 dreq", {14'd0, rx_dreq, tx_dreq},
              {14'd0, m_rx & m_st[3], m_tx & m_st[4]});
        @(posedge clk);
        v = f_vec();
        if (rd && s == 2'd2 && v != 0) m_st[v - 1] = 1'b0;
        m_st = m_st | (set & DEF);
        if (wr && s == 2'd0) m_msk = wd[4:0];
        if (wr && s == 2'd3) begin
            m_rx = wd[15]; m_tx = wd[7];
            if (wd[15]) m_msk[3] = 1'b0;
            if (wd[7])  m_msk[4] = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; flag_set = 16'hFFFF; acc_wr = 1'b0; acc_rd = 1'b0;
        @(negedge clk);
        flag_set = '0;
        @(negedge clk);
        rst = 1'b0;
        m_st = '0; m_msk = '0; m_rx = 1'b0; m_tx = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R1 reset state
        for (int s = 0; s < 4; s++) step(0, 1, 2'(s), '0, '0, "R1 reset read");
        // R2 mask keeps low 5 bits
        step(1, 0, 2'd0, 16'hFFFF, '0, "R2");
        step(0, 1, 2'd0, '0, '0, "R2 mask read");
        // R3 all pulses, only flag positions stick; R4 busy live
        step(0, 0, 2'd1, '0, 16'hFFFF, "R3");
        bus_busy = 1'b0;
        step(0, 1, 2'd1, '0, '0, "R3 status read");
        bus_busy = 1'b1;
        step(0, 1, 2'd1, '0, '0, "R4 busy bit");
        bus_busy = 1'b0;
        // R11 status/vector writes inert
        step(1, 0, 2'd1, 16'h0000, '0, "R11");
        step(1, 0, 2'd2, 16'hFFFF, '0, "R11");
        step(0, 1, 2'd1, '0, '0, "R11 status after write");
        // R6 drain: expect 2,3,4,5 then 0
        for (int k = 0; k < 5; k++) step(0, 1, 2'd2, '0, '0, "R6 vector drain");
        step(0, 1, 2'd1, '0, '0, "R6 other bits kept");
        // R7 ack collides with fresh set of same flag
        step(0, 0, 2'd0, '0, 16'h0004, "R7");
        step(0, 1, 2'd2, '0, 16'h0004, "R7 vector");
        step(0, 1, 2'd1, '0, '0, "R7 flag survives");
        // R8 / R9 DMA enables drop mask bits
        step(1, 0, 2'd0, 16'h001F, '0, "R9");
        step(1, 0, 2'd3, 16'hFFFF, '0, "R8");
        step(0, 1, 2'd3, '0, '0, "R8 dma read");
        step(0, 1, 2'd0, '0, '0, "R9 mask after dma");
        // R10 requests follow ready flags
        step(0, 0, 2'd0, '0, 16'h0018, "R10");
        step(0, 1, 2'd1, '0, '0, "R10 status");
        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [1:0] s;
            bit wr, rd;
            logic [15:0] set;
            s   = 2'($urandom_range(0, 3));
            wr  = ($urandom_range(0, 3) == 0);
            rd  = !wr && ($urandom_range(0, 1) == 1);
            set = ($urandom_range(0, 2) == 0) ? 16'($urandom) : 16'h0;
            bus_busy = 1'($urandom);
            if (n == 300) do_reset();
            step(wr, rd, s, 16'($urandom), set,
                 s == 2'd0 ? "R2 rand" : s == 2'd1 ? "R3 rand" : s == 2'd2 ? "R6 rand" : "R8 rand");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule